// File: doc/BRIEF.md
# Four-Voice Sample Mixer with Selectable Clipping

This block turns the single-bit outputs of four sound voices (three tone voices and one noise voice) into one 8-bit unsigned sample for a DAC. It counts how many voice bits are high, scales that count by a 4-bit master volume, and passes the resulting level through a fixed gain of 1.53125 (49/32). In the default arithmetic the gain is applied first, a constant of 130 is added afterwards, and the sum is saturated at 255. Loud passages therefore clip hard and distort.

A second arithmetic path adds a small offset of 10 before the gain and leaves out the large offset after it. In this path every result stays between 15 and 255 and is never cut off. A small sequence detector watches the register-write port. When it sees a fixed four-write pattern to one address, it flips between the two paths. The selected path is held through the ordinary reset and returns to the default only on a power-on reset.

Top module: `four_voice_mixer`

## Requirements
- R1: While `rst` or `por` is high at a rising edge, `sample` is 0 after that edge.
- R2: The mixed level L is the number of high bits of `voice_bits` times `volume` times 2. `sample` reflects the inputs present at the previous rising edge, so it has one cycle of latency.
- R3: In the default (clipping) mode, `sample` = min(255, floor(L*49/32) + 130).
- R4: The clipping boundary in the default mode: three active voices at volume 13 give 249, and three active voices at volume 14 give 255 (saturated). Four voices at volume 15 also give 255.
- R5: In the no-clip mode, `sample` = floor((L+10)*49/32). This ranges from 15 at L=0 to 199 at L=120 and is never saturated.
- R6: Four consecutive enabled writes to address 0xE with data 0xA5, 0x5A, 0xC3, 0x3C, in that order, toggle the mode. The new mode shows in `sample` from the second rising edge after the fourth write onward. Cycles with `wr_en` low do not advance or break the pattern.
- R7: A high `rst` with `por` low leaves the mode unchanged.
- R8: A high `por` returns the mode to the default (clipping) mode.
- R9: An enabled write that does not match the next expected address and data abandons the pattern. If that write is 0xA5 to address 0xE, it counts as the first step of a new attempt. Writes made while `rst` or `por` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; keeps the mode |
| por | input | 1 | Synchronous active-high power-on reset; clears the mode |
| voice_bits | input | 4 | One bit per voice: three tone voices and one noise voice |
| volume | input | 4 | Master volume, 0 to 15 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| sample | output | 8 | Registered unsigned DAC sample |

## Verification
Every combination of voice patterns with no, one, two, three and four active voices is swept against volumes 0, 1, 7, 13, 14 and 15 in both modes. The 13-to-14 step with three voices separates correct saturation from wrap-around and from a wrong point where saturation starts. The volume-1 results show floor rounding of the 49/32 gain. Level 0 tells the two offset orders apart (130 against 15).

The mode detector is driven with:
- a complete pattern;
- a pattern broken in the middle;
- a pattern broken by a write to another address;
- a pattern that restarts on a repeated first byte;
- a pattern spread over cycles with no write.

Resets are placed between mode changes, which separates the ordinary reset from the power-on reset.

// File: rtl/mixer_pkg.sv
package mixer_pkg;

  typedef enum logic {
    MODE_CLIP   = 1'b0,
    MODE_NOCLIP = 1'b1
  } mix_mode_e;

  localparam int UNLOCK_LEN = 4;

  // Data bytes of the mode-toggle write pattern, in required order.
  function automatic logic [7:0] unlock_byte(input int idx);
    case (idx)
      0:       return 8'hA5;
      1:       return 8'h5A;
      2:       return 8'hC3;
      default: return 8'h3C;
    endcase
  endfunction

endpackage

// File: rtl/voice_popcount.sv
module voice_popcount #(
  parameter int NUM_VOICES = 4,
  parameter int CNT_W      = $clog2(NUM_VOICES + 1)
) (
  input  logic [NUM_VOICES-1:0] bits_in,
  output logic [CNT_W-1:0]      active_cnt
);

  logic [CNT_W-1:0] partial [NUM_VOICES+1];

  assign partial[0] = '0;

  generate
    for (genvar g = 0; g < NUM_VOICES; g++) begin : g_add
      assign partial[g+1] = partial[g] + CNT_W'(bits_in[g]);
    end
  endgenerate

  assign active_cnt = partial[NUM_VOICES];

  // R2: the count of active voices never exceeds the number of voices
  always_comb begin
    p_count_max_r2: assert (active_cnt <= CNT_W'(NUM_VOICES))
      else $error("voice count above voice total");
  end

endmodule

// File: rtl/gain_shaper.sv
module gain_shaper #(
  parameter int LVL_W       = 8,
  parameter int OUT_W       = 8,
  parameter int CLIP_OFFSET = 130,
  parameter int PRE_OFFSET  = 10
) (
  input  logic [LVL_W-1:0] level,
  input  logic             noclip,
  output logic [OUT_W-1:0] shaped
);

  localparam int WIDE_W = LVL_W + 8;
  localparam int MAX_V  = (1 << OUT_W) - 1;

  logic [WIDE_W-1:0] pre_sum;
  logic [WIDE_W-1:0] prod49;
  logic [WIDE_W-1:0] scaled;
  logic [WIDE_W-1:0] post_sum;

  always_comb begin
    // No-clip path moves the offset in front of the gain.
    pre_sum  = WIDE_W'(level) + (noclip ? WIDE_W'(PRE_OFFSET) : '0);
    // Gain 1.53125 = 49/32 = x + x/2 + x/32, kept exact before the final shift.
    prod49   = (pre_sum << 5) + (pre_sum << 4) + pre_sum;
    scaled   = prod49 >> 5;
    post_sum = scaled + (noclip ? '0 : WIDE_W'(CLIP_OFFSET));
    if (post_sum > WIDE_W'(MAX_V)) shaped = '1;
    else                           shaped = post_sum[OUT_W-1:0];
  end

endmodule

// File: rtl/unlock_detector.sv
module unlock_detector
  import mixer_pkg::*;
#(
  parameter int          ADDR_W    = 4,
  parameter int          DATA_W    = 8,
  parameter logic [3:0]  KEY_ADDR  = 4'hE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              por,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output mix_mode_e         mode
);

  localparam int IDX_W = $clog2(UNLOCK_LEN);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(UNLOCK_LEN - 1);

  logic [IDX_W-1:0] step_q;
  logic             addr_ok;
  logic             hit_next;
  logic             hit_first;

  assign addr_ok   = (wr_addr == ADDR_W'(KEY_ADDR));
  assign hit_next  = addr_ok && (wr_data == DATA_W'(unlock_byte(int'(step_q))));
  assign hit_first = addr_ok && (wr_data == DATA_W'(unlock_byte(0)));

  always_ff @(posedge clk) begin
    if (por) begin
      step_q <= '0;
      mode   <= MODE_CLIP;
    end else if (rst) begin
      step_q <= '0;
    end else if (wr_en) begin
      if (hit_next) begin
        if (step_q == LAST_IDX) begin
          step_q <= '0;
          mode   <= (mode == MODE_CLIP) ? MODE_NOCLIP : MODE_CLIP;
        end else begin
          step_q <= step_q + 1'b1;
        end
      end else if (hit_first) begin
        step_q <= IDX_W'(1);
      end else begin
        step_q <= '0;
      end
    end
  end

  // R7: ordinary reset leaves the mode alone
  p_mode_keep_r7: assert property (@(posedge clk) disable iff (por)
    rst |=> $stable(mode))
    else $error("mode changed across ordinary reset");

  // R8: power-on reset returns to clipping mode
  p_por_clear_r8: assert property (@(posedge clk) disable iff (rst)
    por |=> (mode == MODE_CLIP))
    else $error("mode not cleared by power-on reset");

  // R6: without a write the mode cannot move
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst || por)
    !wr_en |=> $stable(mode))
    else $error("mode changed without a write");

endmodule

// File: rtl/four_voice_mixer.sv
module four_voice_mixer
  import mixer_pkg::*;
#(
  parameter int         NUM_VOICES  = 4,
  parameter int         VOL_W       = 4,
  parameter int         OUT_W       = 8,
  parameter int         LEVEL_SHIFT = 1,
  parameter int         CLIP_OFFSET = 130,
  parameter int         PRE_OFFSET  = 10,
  parameter int         ADDR_W      = 4,
  parameter int         DATA_W      = 8,
  parameter logic [3:0] KEY_ADDR    = 4'hE
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  por,
  input  logic [NUM_VOICES-1:0] voice_bits,
  input  logic [VOL_W-1:0]      volume,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [DATA_W-1:0]     wr_data,
  output logic [OUT_W-1:0]      sample
);

  localparam int CNT_W  = $clog2(NUM_VOICES + 1);
  localparam int PROD_W = CNT_W + VOL_W;
  localparam int LVL_W  = PROD_W + LEVEL_SHIFT;

  logic [CNT_W-1:0]  active_cnt;
  logic [PROD_W-1:0] cnt_x_vol;
  logic [LVL_W-1:0]  level;
  logic [OUT_W-1:0]  shaped;
  mix_mode_e         mode;

  voice_popcount #(
    .NUM_VOICES (NUM_VOICES),
    .CNT_W      (CNT_W)
  ) i_popcount (
    .bits_in    (voice_bits),
    .active_cnt (active_cnt)
  );

  assign cnt_x_vol = PROD_W'(active_cnt) * PROD_W'(volume);
  assign level     = LVL_W'(cnt_x_vol) << LEVEL_SHIFT;

  unlock_detector #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .KEY_ADDR (KEY_ADDR)
  ) i_unlock (
    .clk     (clk),
    .rst     (rst),
    .por     (por),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .mode    (mode)
  );

  gain_shaper #(
    .LVL_W       (LVL_W),
    .OUT_W       (OUT_W),
    .CLIP_OFFSET (CLIP_OFFSET),
    .PRE_OFFSET  (PRE_OFFSET)
  ) i_shaper (
    .level  (level),
    .noclip (mode == MODE_NOCLIP),
    .shaped (shaped)
  );

  always_ff @(posedge clk) begin
    if (rst || por) sample <= '0;
    else            sample <= shaped;
  end

  // R3: clipping mode never drops below its post-gain offset
  p_clip_floor_r3: assert property (@(posedge clk) disable iff (rst || por)
    (mode == MODE_CLIP) |=> (sample >= OUT_W'(CLIP_OFFSET)))
    else $error("clip-mode sample below offset");

  // R5: no-clip mode stays at or above its scaled floor
  p_noclip_floor_r5: assert property (@(posedge clk) disable iff (rst || por)
    (mode == MODE_NOCLIP) |=> (sample >= OUT_W'((PRE_OFFSET * 49) / 32)))
    else $error("no-clip sample below floor");

  // R2: silent voices give the mode's rest level one cycle later
  p_silent_r2: assert property (@(posedge clk) disable iff (rst || por)
    (voice_bits == '0 && mode == MODE_CLIP) |=> (sample == OUT_W'(CLIP_OFFSET)))
    else $error("silent input did not give rest level");

endmodule

// File: tb/test_four_voice_mixer.sv
module test_four_voice_mixer;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       por = 1'b1;
  logic [3:0] voice_bits = '0;
  logic [3:0] volume = '0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] sample;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  int m_mode   = 0;
  int m_step   = 0;
  int m_sample = 0;

  always #5 clk = ~clk;

  four_voice_mixer i_four_voice_mixer (
    .clk(clk), .rst(rst), .por(por), .voice_bits(voice_bits), .volume(volume),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .sample(sample)
  );

  function automatic int key(input int i);
    case (i)
      0: return 'hA5;
      1: return 'h5A;
      2: return 'hC3;
      default: return 'h3C;
    endcase
  endfunction

  function automatic int ref_out(input int ones, input int vol, input int md);
    int lv;
    int r;
    lv = ones * vol * 2;
    if (md != 0) r = ((lv + 10) * 49) / 32;
    else begin
      r = (lv * 49) / 32 + 130;
      if (r > 255) r = 255;
    end
    return r;
  endfunction

  task automatic cyc(input string tag);
    int nxt;
    @(posedge clk);
    if (rst || por) nxt = 0;
    else nxt = ref_out($countones(voice_bits), int'(volume), m_mode);
    if (por) begin
      m_step = 0;
      m_mode = 0;
    end else if (rst) begin
      m_step = 0;
    end else if (wr_en) begin
      if (wr_addr == 4'hE && int'(wr_data) == key(m_step)) begin
        if (m_step == 3) begin
          m_step = 0;
          m_mode = 1 - m_mode;
        end else m_step++;
      end else if (wr_addr == 4'hE && int'(wr_data) == key(0)) m_step = 1;
      else m_step = 0;
    end
    m_sample = nxt;
    @(negedge clk);
    checks++;
    if (int'(sample) != m_sample) begin
      fails++;
      $display("FAIL %s: sample actual=%0d expected=%0d", tag, sample, m_sample);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d, input string tag);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    cyc(tag);
    wr_en = 1'b0;
  endtask

  task automatic unlock(input string tag);
    for (int i = 0; i < 4; i++) wr(4'hE, 8'(key(i)), tag);
  endtask

  task automatic sweep(input string tag);
    logic [3:0] pats [5] = '{4'b0000, 4'b0100, 4'b1010, 4'b0111, 4'b1111};
    int vols [6] = '{0, 1, 7, 13, 14, 15};
    for (int p = 0; p < 5; p++)
      for (int v = 0; v < 6; v++) begin
        voice_bits = pats[p];
        volume = 4'(vols[v]);
        cyc(tag);
      end
  endtask

  task automatic probe(input int ones, input int vol, input int exp_v, input string tag);
    voice_bits = 4'((1 << ones) - 1);
    volume = 4'(vol);
    cyc(tag);
    checks++;
    if (int'(sample) != exp_v) begin
      fails++;
      $display("FAIL %s: fixed point actual=%0d expected=%0d", tag, sample, exp_v);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    cyc("R1 power-on");
    cyc("R1 power-on");
    por = 1'b0;
    voice_bits = 4'hF; volume = 4'hF;
    cyc("R1 rst only");
    rst = 1'b0;

    sweep("R2 R3 default sweep");
    probe(0, 9, 130, "R3 silent offset");
    probe(1, 1, 133, "R3 floor rounding");
    probe(3, 13, 249, "R4 below clip");
    probe(3, 14, 255, "R4 clipped");
    probe(4, 15, 255, "R4 full clipped");

    voice_bits = '0;
    wr(4'hE, 8'hA5, "R9 broken pattern");
    wr(4'hE, 8'h5A, "R9 broken pattern");
    wr(4'hE, 8'h00, "R9 broken pattern");
    wr(4'hE, 8'h3C, "R9 broken pattern");
    probe(0, 0, 130, "R9 no toggle after mismatch");

    wr(4'hE, 8'hA5, "R9 other address");
    wr(4'h3, 8'h5A, "R9 other address");
    wr(4'hE, 8'hC3, "R9 other address");
    wr(4'hE, 8'h3C, "R9 other address");
    probe(0, 0, 130, "R9 no toggle after address miss");

    wr(4'hE, 8'hA5, "R9 restart");
    wr(4'hE, 8'hA5, "R9 restart");
    wr(4'hE, 8'h5A, "R9 restart");
    cyc("R6 idle gap");
    cyc("R6 idle gap");
    wr(4'hE, 8'hC3, "R9 restart");
    wr(4'hE, 8'h3C, "R9 restart");
    probe(0, 0, 15, "R6 R9 toggled after restart");

    sweep("R5 no-clip sweep");
    probe(4, 15, 199, "R5 no-clip max");
    probe(3, 14, 143, "R5 no-clip no saturation");

    rst = 1'b1;
    wr(4'hE, 8'hA5, "R9 write in reset");
    cyc("R1 R7 reset");
    rst = 1'b0;
    probe(0, 0, 15, "R7 mode kept over reset");
    wr(4'hE, 8'h5A, "R9 reset cleared progress");
    wr(4'hE, 8'hC3, "R9 reset cleared progress");
    wr(4'hE, 8'h3C, "R9 reset cleared progress");
    probe(0, 0, 15, "R9 no toggle from stale step");

    unlock("R6 toggle back");
    probe(0, 0, 130, "R6 back to clip");
    unlock("R6 toggle again");
    probe(2, 7, ((28 + 10) * 49) / 32, "R6 no-clip again");

    por = 1'b1;
    cyc("R1 R8 power-on");
    por = 1'b0;
    probe(0, 0, 130, "R8 cleared to clip");
    sweep("R3 after power-on");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule